// File: doc/BRIEF.md
# Filtered Operand Retention Latch Cache

This block is a small, fully associative store of recently written-back results. Each entry is keyed by the result's reorder-buffer tag. In-flight source operands are read from this store and never from the reorder buffer, so the reorder buffer needs no read ports for source operands. Every lookup port compares its requested producer tag against all valid entries in parallel. It returns a hit flag and the data in the same cycle.

Writebacks are filtered before they are stored. A tracker watches dispatch and keeps the latest producer tag for every architectural register. When a younger dispatch names the same destination again, the older producer is marked as renamed away. When a marked producer writes back, its result is short-lived: no later instruction can name it as a source, so the result is dropped. Only results that can still be read take up the few latches.

The writeback decision takes one of three named values: WB_IDLE (no writeback), WB_DROP (short-lived) and WB_ALLOC (store). A store replaces the oldest stored entry, in the order results were produced. A flush empties the store and clears all renaming marks in one cycle.

Top module: `retain_cache`

## Requirements
- R1: After reset, and in the cycle after a flush, every lookup misses. The one exception is a lookup that matches a same-cycle writeback.
- R2: A lookup whose tag matches a stored entry returns hit high and that entry's data in the same cycle. At most one entry matches any tag.
- R3: A lookup that matches no stored entry and no same-cycle writeback returns hit low and data zero.
- R4: A producer whose destination register was named again by a later dispatch, in a cycle before its writeback, is not stored. A later lookup of its tag misses. Its renaming mark is cleared by that writeback.
- R5: A producer whose destination register was not named again before its writeback is stored. From the next cycle on, lookups of its tag hit with its data.
- R6: When all entries are valid, a new store replaces the entry that was stored earliest. All other entries are kept.
- R7: A lookup in the same cycle as a writeback of the same tag returns hit high and the writeback data, whether or not that writeback is stored.
- R8: A flush clears all renaming marks. A writeback after a flush is stored even if its register had been renamed before the flush.
- R9: A dispatch in the same cycle as a writeback does not change that writeback's store or drop decision.
- R10: The two lookup ports work independently and at the same time, each on its own tag.
- R11: A dropped writeback does not move the replacement order. The next store replaces the same entry it would have replaced without the drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the store and clears all renaming marks |
| disp_valid | input | 1 | A dispatch with a destination register is present |
| disp_areg | input | 5 | Destination architectural register of the dispatch |
| disp_tag | input | 5 | Reorder-buffer tag given to the dispatch |
| wb_valid | input | 1 | A writeback is present |
| wb_tag | input | 5 | Tag of the writeback |
| wb_data | input | 32 | Result value of the writeback |
| rd_tag | input | 2x5 | Producer tag requested by each lookup port |
| rd_hit | output | 2 | Hit flag of each lookup port |
| rd_data | output | 2x32 | Data of each lookup port, zero on a miss |

## Verification
Lookup results are combinational, so a lookup is due in the cycle its tag is presented. A same-cycle writeback is forwarded to it in that cycle. A stored writeback is visible from the cycle after the edge that captures it. A dispatch affects only writebacks that arrive after the edge that captures the dispatch. A flush takes effect from the cycle after its edge. The bench drives every input just after the falling edge and reads the lookup outputs one nanosecond later. Each result is therefore read either in the cycle it is due, or after the single rising edge that makes it due.

// File: rtl/retain_pkg.sv
package retain_pkg;

    typedef enum logic [1:0] {
        WB_IDLE  = 2'd0,
        WB_DROP  = 2'd1,
        WB_ALLOC = 2'd2
    } wb_act_e;

endpackage

// File: rtl/retain_producer_tracker.sv
module retain_producer_tracker
    import retain_pkg::*;
#(
    parameter int NUM_AREGS = 32,
    parameter int NUM_TAGS  = 32,
    localparam int AREG_W   = $clog2(NUM_AREGS),
    localparam int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    input  logic [AREG_W-1:0] disp_areg,
    input  logic [TAG_W-1:0]  disp_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    output wb_act_e           wb_act
);

    logic [TAG_W-1:0]     latest_q [NUM_AREGS];
    logic [NUM_AREGS-1:0] latest_vld_q;
    logic [NUM_TAGS-1:0]  renamed_q;

    // Decision uses only marks captured at earlier edges.
    always_comb begin
        if (!wb_valid) begin
            wb_act = WB_IDLE;
        end else if (renamed_q[wb_tag]) begin
            wb_act = WB_DROP;
        end else begin
            wb_act = WB_ALLOC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latest_vld_q <= '0;
            renamed_q    <= '0;
        end else if (flush) begin
            latest_vld_q <= '0;
            renamed_q    <= '0;
        end else begin
            if (disp_valid) begin
                if (latest_vld_q[disp_areg]) begin
                    renamed_q[latest_q[disp_areg]] <= 1'b1;
                end
                renamed_q[disp_tag]     <= 1'b0;
                latest_q[disp_areg]     <= disp_tag;
                latest_vld_q[disp_areg] <= 1'b1;
            end
            if (wb_valid) begin
                renamed_q[wb_tag] <= 1'b0;
            end
        end
    end

    // R4: the mark of a tag that wrote back is cleared for reuse
    assert_wb_clears_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !flush) |=> !renamed_q[$past(wb_tag)]);

    // R8: nothing is dropped right after a flush
    assert_no_drop_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wb_act != WB_DROP));

endmodule

// File: rtl/retain_latch_array.sv
module retain_latch_array #(
    parameter int NUM_ENTRIES = 2,
    parameter int TAG_W       = 5,
    parameter int DATA_W      = 32,
    parameter int NUM_RD      = 2,
    localparam int PTR_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           alloc_en,
    input  logic                           wb_valid,
    input  logic [TAG_W-1:0]               wb_tag,
    input  logic [DATA_W-1:0]              wb_data,
    input  logic [NUM_RD-1:0][TAG_W-1:0]   rd_tag,
    output logic [NUM_RD-1:0]              rd_hit,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

    logic [NUM_ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]       tag_q  [NUM_ENTRIES];
    logic [DATA_W-1:0]      data_q [NUM_ENTRIES];
    logic [PTR_W-1:0]       wr_ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            wr_ptr_q <= '0;
        end else if (flush) begin
            vld_q    <= '0;
            wr_ptr_q <= '0;
        end else if (alloc_en) begin
            vld_q[wr_ptr_q]  <= 1'b1;
            tag_q[wr_ptr_q]  <= wb_tag;
            data_q[wr_ptr_q] <= wb_data;
            if (wr_ptr_q == PTR_W'(NUM_ENTRIES - 1)) begin
                wr_ptr_q <= '0;
            end else begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        logic [NUM_ENTRIES-1:0] match;
        logic [DATA_W-1:0]      sel_data;
        logic                   byp;

        always_comb begin
            sel_data = '0;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                match[e] = vld_q[e] && (tag_q[e] == rd_tag[p]);
                if (match[e]) begin
                    sel_data = sel_data | data_q[e];
                end
            end
            byp = wb_valid && (wb_tag == rd_tag[p]);
            rd_hit[p]  = byp || (|match);
            rd_data[p] = byp ? wb_data : sel_data;
        end

        // R2: no tag is held twice
        assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match));

        // R3: a miss returns zero data
        assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_hit[p] |-> (rd_data[p] == '0));

        // R7: same-cycle writeback is forwarded
        assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_valid && (wb_tag == rd_tag[p])) |-> (rd_hit[p] && (rd_data[p] == wb_data)));

        // R1: empty after a flush
        assert_empty_after_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (!rd_hit[p] || (wb_valid && (wb_tag == rd_tag[p]))));
    end

    // R11: replacement order moves only on a store
    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_en && !flush) |=> $stable(wr_ptr_q));

endmodule

// File: rtl/retain_cache.sv
module retain_cache
    import retain_pkg::*;
#(
    parameter int NUM_ENTRIES = 2,
    parameter int NUM_AREGS   = 32,
    parameter int NUM_TAGS    = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_RD      = 2,
    localparam int AREG_W     = $clog2(NUM_AREGS),
    localparam int TAG_W      = $clog2(NUM_TAGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           disp_valid,
    input  logic [AREG_W-1:0]              disp_areg,
    input  logic [TAG_W-1:0]               disp_tag,
    input  logic                           wb_valid,
    input  logic [TAG_W-1:0]               wb_tag,
    input  logic [DATA_W-1:0]              wb_data,
    input  logic [NUM_RD-1:0][TAG_W-1:0]   rd_tag,
    output logic [NUM_RD-1:0]              rd_hit,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data
);

    wb_act_e wb_act;
    logic    alloc_en;

    retain_producer_tracker #(
        .NUM_AREGS (NUM_AREGS),
        .NUM_TAGS  (NUM_TAGS)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .disp_valid (disp_valid),
        .disp_areg  (disp_areg),
        .disp_tag   (disp_tag),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_act     (wb_act)
    );

    always_comb begin
        unique case (wb_act)
            WB_ALLOC: alloc_en = !flush;
            WB_DROP:  alloc_en = 1'b0;
            default:  alloc_en = 1'b0;
        endcase
    end

    retain_latch_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .TAG_W       (TAG_W),
        .DATA_W      (DATA_W),
        .NUM_RD      (NUM_RD)
    ) u_latches (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .alloc_en (alloc_en),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag),
        .wb_data  (wb_data),
        .rd_tag   (rd_tag),
        .rd_hit   (rd_hit),
        .rd_data  (rd_data)
    );

    // R5: a writeback with no drop decision is stored
    assert_store_when_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !flush && (wb_act != WB_DROP)) |-> alloc_en);

endmodule

// File: tb/sim_retain_cache.sv
`timescale 1ns/100ps
module sim_retain_cache;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             disp_valid = 1'b0;
    logic [4:0]       disp_areg = '0;
    logic [4:0]       disp_tag = '0;
    logic             wb_valid = 1'b0;
    logic [4:0]       wb_tag = '0;
    logic [31:0]      wb_data = '0;
    logic [1:0][4:0]  rd_tag = '0;
    logic [1:0]       rd_hit;
    logic [1:0][31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    retain_cache u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_areg(disp_areg), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .rd_tag(rd_tag), .rd_hit(rd_hit), .rd_data(rd_data)
    );

    // Present a tag on one port and compare within the same cycle.
    task automatic look(input int p, input logic [4:0] t, input logic eh,
                        input logic [31:0] ed, input string req);
        rd_tag[p] = t;
        #1;
        n_chk++;
        if (rd_hit[p] !== eh || rd_data[p] !== (eh ? ed : 32'h0)) begin
            n_fail++;
            $display("FAIL %s port%0d tag%0d: hit=%b data=%h expected hit=%b data=%h",
                     req, p, t, rd_hit[p], rd_data[p], eh, eh ? ed : 32'h0);
        end
    endtask

    task automatic dispatch(input logic [4:0] a, input logic [4:0] t);
        @(negedge clk);
        disp_valid = 1'b1; disp_areg = a; disp_tag = t;
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic writeback(input logic [4:0] t, input logic [31:0] d);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = t; wb_data = d;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic t_reset;
        look(0, 5'd0, 1'b0, 0, "R1");
        look(1, 5'd1, 1'b0, 0, "R1");
        look(0, 5'd31, 1'b0, 0, "R3");
    endtask

    task automatic t_store;
        dispatch(5'd3, 5'd1);
        writeback(5'd1, 32'hA0A0_0001);
        look(0, 5'd1, 1'b1, 32'hA0A0_0001, "R5");
        look(1, 5'd1, 1'b1, 32'hA0A0_0001, "R2");
        look(1, 5'd7, 1'b0, 0, "R3");
    endtask

    task automatic t_short;
        dispatch(5'd4, 5'd2);
        dispatch(5'd4, 5'd3);
        writeback(5'd2, 32'hB0B0_0002);
        look(0, 5'd2, 1'b0, 0, "R4");
        look(1, 5'd1, 1'b1, 32'hA0A0_0001, "R4");
        writeback(5'd3, 32'hC0C0_0003);
        look(0, 5'd3, 1'b1, 32'hC0C0_0003, "R5");
    endtask

    // Entries now hold tag1 (oldest) and tag3.
    task automatic t_fifo;
        dispatch(5'd5, 5'd4);
        writeback(5'd4, 32'hD0D0_0004);
        look(0, 5'd1, 1'b0, 0, "R6");
        look(0, 5'd3, 1'b1, 32'hC0C0_0003, "R6");
        look(1, 5'd4, 1'b1, 32'hD0D0_0004, "R10");
        look(0, 5'd3, 1'b1, 32'hC0C0_0003, "R10");
    endtask

    // Entries: tag3 (oldest), tag4.
    task automatic t_bypass;
        dispatch(5'd6, 5'd5);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = 5'd5; wb_data = 32'hE0E0_0005;
        look(0, 5'd5, 1'b1, 32'hE0E0_0005, "R7");
        look(1, 5'd5, 1'b1, 32'hE0E0_0005, "R7");
        @(negedge clk);
        wb_valid = 1'b0;
        look(0, 5'd5, 1'b1, 32'hE0E0_0005, "R6");
        look(1, 5'd3, 1'b0, 0, "R6");
    endtask

    // Entries: tag4 (oldest), tag5.
    task automatic t_same_cycle;
        dispatch(5'd7, 5'd6);
        @(negedge clk);
        wb_valid = 1'b1; wb_tag = 5'd6; wb_data = 32'hF0F0_0006;
        disp_valid = 1'b1; disp_areg = 5'd7; disp_tag = 5'd8;
        @(negedge clk);
        wb_valid = 1'b0; disp_valid = 1'b0;
        look(0, 5'd6, 1'b1, 32'hF0F0_0006, "R9");
        look(1, 5'd4, 1'b0, 0, "R6");
    endtask

    // Entries: tag5 (oldest), tag6.
    task automatic t_drop_order;
        dispatch(5'd8, 5'd9);
        dispatch(5'd8, 5'd10);
        writeback(5'd9, 32'h1111_0009);
        look(0, 5'd9, 1'b0, 0, "R4");
        writeback(5'd10, 32'h2222_000A);
        look(0, 5'd5, 1'b0, 0, "R11");
        look(1, 5'd6, 1'b1, 32'hF0F0_0006, "R11");
        look(0, 5'd10, 1'b1, 32'h2222_000A, "R11");
    endtask

    task automatic t_flush;
        dispatch(5'd9, 5'd11);
        dispatch(5'd9, 5'd12);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        look(0, 5'd6, 1'b0, 0, "R1");
        look(1, 5'd10, 1'b0, 0, "R1");
        writeback(5'd11, 32'h3333_000B);
        look(0, 5'd11, 1'b1, 32'h3333_000B, "R8");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_store;
        t_short;
        t_fifo;
        t_bypass;
        t_same_cycle;
        t_drop_order;
        t_flush;
        finish_run;
    end

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run;
    end

endmodule